// File: doc/BRIEF.md
# Network Controller Interrupt Status and Mask

This block holds the interrupt cause register of a network interface controller, together with its interrupt enable register and a single level interrupt line to the host. Single-cycle event strobes from the receive path, the transmit path, the local DMA, the tally counters and the remote DMA each latch a sticky status bit. The host reads either register and writes it over a simple synchronous register bus. It acknowledges causes by writing ones to the status register.

The top status bit is a reset indicator and not an interrupt cause. Controller state drives it: entering reset or a receive ring overflow sets it, and a start command or the removal of a packet from the ring clears it. Host writes do not change it and it never raises the interrupt line. All other bits are write-one-to-clear. When a hardware set and a host clear hit the same bit in one cycle, the set wins, so no event is lost.

Top module: `nic_irq_status`

## Requirements
- R1: After reset the status register reads 0x80 (only the reset indicator set), the enable register reads 0x00 and `irq` is low.
- R2: Status bit positions are: bit 0 receive OK, bit 1 transmit OK, bit 2 receive error, bit 3 transmit error, bit 4 ring overwrite warning, bit 5 tally overflow, bit 6 remote DMA done, bit 7 reset indicator. A strobe on a source sets its bit at the next clock edge. The bit stays set until it is cleared.
- R3: Any one of the four receive fault strobes (CRC, alignment, FIFO overrun, missed packet) sets bit 2. Either transmit fault strobe (excess collisions, FIFO underrun) sets bit 3.
- R4: Bit 5 sets on the cycle any tally counter MSB input goes from low to high. An MSB that stays high does not set the bit again after the host clears it.
- R5: A host write to the status address clears every bit 0..6 whose write data bit is 1 and leaves every bit whose write data bit is 0 unchanged.
- R6: If a source strobe and a host clear of the same bit fall in the same cycle, the bit ends up set.
- R7: `irq` is a register. It is high in the cycle after any bit 0..6 is set with its enable bit also set. It goes low in the cycle after the last such bit is cleared or disabled, and stays high while any such bit remains.
- R8: The enable register is written and read at its own address. Bit n enables status bit n for n = 0..6, bit 7 always reads 0, and a disabled cause still latches in the status register.
- R9: Host writes never change the reset indicator (bit 7), and this bit never drives `irq`.
- R10: The reset indicator is set by the reset-entry or ring-overflow strobe and cleared by the start or packet-removed strobe; a set and a clear in the same cycle leave it set.
- R11: A write to any other address changes neither register, and a read of any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| rx_ok | input | 1 | Good packet received |
| tx_ok | input | 1 | Packet sent without fault |
| rx_crc_err | input | 1 | Received packet with CRC fault |
| rx_align_err | input | 1 | Received packet with alignment fault |
| rx_fifo_ovr | input | 1 | Receive FIFO overrun |
| rx_missed | input | 1 | Packet missed |
| tx_coll_err | input | 1 | Transmit aborted on excess collisions |
| tx_fifo_urun | input | 1 | Transmit FIFO underrun |
| ring_hit | input | 1 | Local DMA reached the ring boundary |
| tally_msb | input | N_TALLY | MSB of each tally counter |
| rdma_done | input | 1 | Remote DMA finished |
| ctl_reset_enter | input | 1 | Controller enters reset state |
| ctl_start | input | 1 | Start command issued |
| ring_ovf | input | 1 | Receive ring overflow |
| ring_pkt_removed | input | 1 | Packet removed from the ring |
| irq | output | 1 | Level interrupt to host |

## Verification
The bench builds the block with its default parameters: a 4-bit address with the status register at 0x7 and the enable register at 0xF, and three tally MSB inputs. Three tally inputs are enough to show that a second counter crossing its MSB re-arms bit 5 while the first one is still held high. The spare address 0x3 gives a decode target for the ignored-write and zero-read cases, and the 7-bit enable field lets the bench disable single causes next to enabled ones.

// File: rtl/nic_irq_status.sv
module nic_irq_status #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h7,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 'hF,
  parameter int N_TALLY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              rx_ok,
  input  logic              tx_ok,
  input  logic              rx_crc_err,
  input  logic              rx_align_err,
  input  logic              rx_fifo_ovr,
  input  logic              rx_missed,
  input  logic              tx_coll_err,
  input  logic              tx_fifo_urun,
  input  logic              ring_hit,
  input  logic [N_TALLY-1:0] tally_msb,
  input  logic              rdma_done,
  input  logic              ctl_reset_enter,
  input  logic              ctl_start,
  input  logic              ring_ovf,
  input  logic              ring_pkt_removed,
  output logic              irq
);

  localparam int NCAUSE = 7;

  logic [NCAUSE-1:0]  cause_q, cause_set, cause_clr, cause_nxt;
  logic [NCAUSE-1:0]  en_q, en_nxt;
  logic               rflag_q, rflag_nxt;
  logic [N_TALLY-1:0] tally_prev_q;
  logic               irq_q;

  wire wr_stat = bus_wr && (bus_addr == STAT_ADDR);
  wire wr_en   = bus_wr && (bus_addr == MASK_ADDR);

  assign cause_set = {
    rdma_done,
    |(tally_msb & ~tally_prev_q),
    ring_hit,
    tx_coll_err | tx_fifo_urun,
    rx_crc_err | rx_align_err | rx_fifo_ovr | rx_missed,
    tx_ok,
    rx_ok
  };

  assign cause_clr = wr_stat ? bus_wdata[NCAUSE-1:0] : '0;
  assign cause_nxt = (cause_q & ~cause_clr) | cause_set;
  assign en_nxt    = wr_en ? bus_wdata[NCAUSE-1:0] : en_q;
  assign rflag_nxt = ctl_reset_enter | ring_ovf |
                     (rflag_q & ~(ctl_start | ring_pkt_removed));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q      <= '0;
      en_q         <= '0;
      rflag_q      <= 1'b1;
      tally_prev_q <= '0;
      irq_q        <= 1'b0;
    end else begin
      cause_q      <= cause_nxt;
      en_q         <= en_nxt;
      rflag_q      <= rflag_nxt;
      tally_prev_q <= tally_msb;
      irq_q        <= |(cause_nxt & en_nxt);
    end
  end

  assign irq = irq_q;

  always_comb begin
    if (bus_addr == STAT_ADDR)      bus_rdata = {rflag_q, cause_q};
    else if (bus_addr == MASK_ADDR) bus_rdata = {1'b0, en_q};
    else                            bus_rdata = 8'h00;
  end

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ok && wr_stat && bus_wdata[0]) |=> cause_q[0]); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[1] && !tx_ok) |=> !cause_q[1]); // R5
  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q[0] && !(wr_stat && bus_wdata[0])) |=> cause_q[0]); // R5
  AST_RFLAG_IGNORES_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !ctl_reset_enter && !ring_ovf && !ctl_start && !ring_pkt_removed)
      |=> $stable(rflag_q)); // R9
  AST_RFLAG_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_q & en_q) == '0) |-> !irq); // R9
  AST_RFLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_reset_enter || ring_ovf) |=> rflag_q); // R10
  AST_EN_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == MASK_ADDR) |-> !bus_rdata[7]); // R8

endmodule

// File: tb/nic_irq_status_tb.sv
`timescale 1ns/1ps
module nic_irq_status_tb_top;
  localparam logic [3:0] SA = 4'h7, MA = 4'hF, XA = 4'h3;
  localparam int RXOK=0, TXOK=1, CRC=2, ALN=3, OVR=4, MIS=5, COL=6, URN=7,
                 HIT=8, RDMA=9, RENT=10, STRT=11, ROVF=12, RREM=13;

  logic clk = 0, rst_n = 0;
  logic [3:0] addr = '0;
  logic wr = 0;
  logic [7:0] wdata = '0, rdata;
  logic [13:0] ev = '0;
  logic [2:0] tally = '0;
  logic irq;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  nic_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rdata(rdata), .rx_ok(ev[RXOK]), .tx_ok(ev[TXOK]), .rx_crc_err(ev[CRC]),
    .rx_align_err(ev[ALN]), .rx_fifo_ovr(ev[OVR]), .rx_missed(ev[MIS]),
    .tx_coll_err(ev[COL]), .tx_fifo_urun(ev[URN]), .ring_hit(ev[HIT]),
    .tally_msb(tally), .rdma_done(ev[RDMA]), .ctl_reset_enter(ev[RENT]),
    .ctl_start(ev[STRT]), .ring_ovf(ev[ROVF]), .ring_pkt_removed(ev[RREM]),
    .irq(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle(logic [13:0] e, logic w, logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    ev = e; wr = w; addr = a; wdata = d;
    @(posedge clk); #1;
    ev = '0; wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic chk_reg(string req, logic [3:0] a, logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    chk_reg("R1 status", SA, 8'h80);
    chk_reg("R1 enable", MA, 8'h00);
    check("R1 irq", irq, 0);
    cycle(14'(1) << STRT, 0, SA, 0);
    chk_reg("R10 start clears", SA, 8'h00);
  endtask

  task automatic t_each_bit();
    int src[7] = '{RXOK, TXOK, CRC, COL, HIT, -1, RDMA};
    for (int i = 0; i < 7; i++) begin
      if (i == 5) continue;
      cycle(14'(1) << src[i], 0, SA, 0);
      chk_reg("R2 bit position", SA, 8'(1 << i));
      cycle('0, 1, SA, 8'hFF);
    end
  endtask

  task automatic t_err_sources();
    int rx[4] = '{CRC, ALN, OVR, MIS};
    int tx[2] = '{COL, URN};
    foreach (rx[i]) begin
      cycle(14'(1) << rx[i], 0, SA, 0);
      chk_reg("R3 rx fault", SA, 8'h04);
      cycle('0, 1, SA, 8'hFF);
    end
    foreach (tx[i]) begin
      cycle(14'(1) << tx[i], 0, SA, 0);
      chk_reg("R3 tx fault", SA, 8'h08);
      cycle('0, 1, SA, 8'hFF);
    end
  endtask

  task automatic t_tally();
    @(negedge clk); tally = 3'b010;
    @(posedge clk); #1;
    chk_reg("R4 msb rise", SA, 8'h20);
    cycle('0, 1, SA, 8'h20);
    cycle('0, 0, SA, 0);
    chk_reg("R4 held msb no reset", SA, 8'h00);
    @(negedge clk); tally = 3'b110;
    @(posedge clk); #1;
    chk_reg("R4 second counter", SA, 8'h20);
    @(negedge clk); tally = 3'b000;
    cycle('0, 1, SA, 8'hFF);
  endtask

  task automatic t_w1c();
    cycle((14'(1) << RXOK) | (14'(1) << TXOK) | (14'(1) << CRC), 0, SA, 0);
    cycle('0, 1, SA, 8'h02);
    chk_reg("R5 clear one", SA, 8'h05);
    cycle('0, 1, SA, 8'h00);
    chk_reg("R5 zero keeps", SA, 8'h05);
    cycle('0, 1, SA, 8'hFF);
    chk_reg("R5 clear all", SA, 8'h00);
  endtask

  task automatic t_set_wins();
    cycle(14'(1) << RXOK, 1, SA, 8'h01);
    chk_reg("R6 set beats clear", SA, 8'h01);
    cycle('0, 1, SA, 8'hFF);
  endtask

  task automatic t_irq();
    cycle('0, 1, MA, 8'h7F);
    check("R7 idle irq", irq, 0);
    cycle(14'(1) << TXOK, 0, SA, 0);
    check("R7 irq rises", irq, 1);
    cycle(14'(1) << RDMA, 0, SA, 0);
    cycle('0, 1, SA, 8'h02);
    check("R7 irq held by other cause", irq, 1);
    cycle('0, 1, SA, 8'h40);
    check("R7 irq falls", irq, 0);
  endtask

  task automatic t_mask();
    cycle('0, 1, MA, 8'hFF);
    chk_reg("R8 enable readback", MA, 8'h7F);
    cycle('0, 1, MA, 8'h01);
    cycle(14'(1) << TXOK, 0, SA, 0);
    chk_reg("R8 disabled still latches", SA, 8'h02);
    check("R8 disabled no irq", irq, 0);
    cycle(14'(1) << RXOK, 0, SA, 0);
    check("R8 enabled irq", irq, 1);
    cycle('0, 1, MA, 8'h00);
    check("R7 disable drops irq", irq, 0);
    cycle('0, 1, SA, 8'hFF);
  endtask

  task automatic t_rflag();
    cycle('0, 1, MA, 8'hFF);
    cycle(14'(1) << ROVF, 0, SA, 0);
    chk_reg("R10 overflow sets", SA, 8'h80);
    check("R9 no irq from flag", irq, 0);
    cycle('0, 1, SA, 8'hFF);
    chk_reg("R9 write ignored", SA, 8'h80);
    cycle(14'(1) << RREM, 0, SA, 0);
    chk_reg("R10 removal clears", SA, 8'h00);
    cycle('0, 1, SA, 8'h00);
    chk_reg("R9 write no set", SA, 8'h00);
    cycle((14'(1) << RENT) | (14'(1) << STRT), 0, SA, 0);
    chk_reg("R10 set wins", SA, 8'h80);
    cycle(14'(1) << STRT, 0, SA, 0);
    cycle('0, 1, MA, 8'h00);
  endtask

  task automatic t_other_addr();
    cycle(14'(1) << RXOK, 0, SA, 0);
    cycle('0, 1, MA, 8'h02);
    cycle('0, 1, XA, 8'hFF);
    chk_reg("R11 status untouched", SA, 8'h01);
    chk_reg("R11 enable untouched", MA, 8'h02);
    chk_reg("R11 other reads zero", XA, 8'h00);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    t_reset();
    t_each_bit();
    t_err_sources();
    t_tally();
    t_w1c();
    t_set_wins();
    t_irq();
    t_mask();
    t_rflag();
    t_other_addr();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule